// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement and Flush

This block tracks in-flight instructions in a circular buffer, in the order they were issued. Each issued instruction takes one slot. The slot index is handed back as its rename tag. Execution units later return a result against that tag. The result can be read through a lookup port until the instruction retires. Retirement takes place only at the oldest slot, at most one per cycle. A retiring register operation drives a register-file write, and a retiring store drives a memory write.

Control hazards and faults are settled only at retirement. When a branch reaches the oldest slot flagged as mispredicted, the whole buffer is discarded. When an instruction reaches the oldest slot with an exception recorded against it, the whole buffer is also discarded, and the faulting tag is reported. Neither case writes any architectural state. A comparator bank tells a load whether an older store still in the buffer targets the same address.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty. `alloc_ready` is 1, `alloc_tag` is 0, and `cm_reg_we`, `cm_mem_we`, `flush` and `lookup_ready` are all 0.
- R2: An accepted allocation receives `alloc_tag`. Successive accepted allocations take consecutive tags modulo DEPTH. `alloc_ready` is 0 while DEPTH slots are occupied.
- R3: When the oldest slot holds a result without a fault or misprediction, it retires in the cycle after its writeback. Kind code 2 (register op) raises `cm_reg_we`, kind code 1 (store) raises `cm_mem_we`, and kind code 0 (branch) raises neither. `cm_dest`, `cm_value` and `cm_tag` carry the slot's contents. At most one slot retires per cycle.
- R4: `lookup_ready` is 1 for an occupied slot whose result has arrived, with `lookup_value` equal to that result. It is 0 otherwise. A result becomes visible the cycle after its writeback.
- R5: A branch reaching the oldest slot with its mispredict flag set raises `flush` with `flush_cause` 0 and `flush_tag` equal to its tag. In the next cycle every slot is empty and `alloc_tag` equals that tag.
- R6: An exception is stored with the result and has no effect until its slot is oldest. It then raises `flush` with `flush_cause` 1 and `flush_tag` set to the slot, without any write, and empties the buffer.
- R7: A writeback naming an unoccupied slot changes nothing. That slot never reports ready from it, even after the slot is later allocated.
- R8: `ld_block` is 1 exactly when an occupied store slot older than `ld_tag` holds a destination equal to `ld_addr`.
- R9: An allocation request while `alloc_ready` is 0 (full, or a flush in this cycle) is ignored and does not move the tail.
- R10: Slots retire strictly in issue order. A completed slot never retires while an older slot is still waiting for its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Request to allocate a slot |
| alloc_kind | input | 2 | 0 branch, 1 store, 2 register op |
| alloc_dest | input | ADDR_W | Register number or store address |
| alloc_ready | output | 1 | A slot can be taken this cycle |
| alloc_tag | output | TAG_W | Tag the next allocation receives |
| wb_valid | input | 1 | Result writeback strobe |
| wb_tag | input | TAG_W | Slot receiving the result |
| wb_value | input | DATA_W | Result value |
| wb_exc | input | 1 | Instruction raised an exception |
| wb_mispredict | input | 1 | Branch was mispredicted |
| lookup_tag | input | TAG_W | Slot to read an operand from |
| lookup_ready | output | 1 | Looked-up result is present |
| lookup_value | output | DATA_W | Looked-up result |
| ld_tag | input | TAG_W | Tag of the load being checked |
| ld_addr | input | ADDR_W | Address of that load |
| ld_block | output | 1 | An older matching store is pending |
| cm_reg_we | output | 1 | Register-file write at retirement |
| cm_mem_we | output | 1 | Memory write at retirement |
| cm_tag | output | TAG_W | Tag of the oldest slot |
| cm_dest | output | ADDR_W | Retiring destination |
| cm_value | output | DATA_W | Retiring value |
| flush | output | 1 | Buffer is being discarded |
| flush_cause | output | 1 | 0 mispredict, 1 exception |
| flush_tag | output | TAG_W | Slot that caused the flush |

## Verification
The hardest case to reach is a flush at the oldest slot while younger slots already hold results. This matters most after the pointers have wrapped, where a wrong tail or a stale valid bit would show up as a later retirement. The stimulus allocates at random, returns results in random order, and often leaves the oldest result until last, so younger results pile up behind it. A small share of results carry faults or mispredictions, which makes flushes occur at many head positions. Directed runs cover the full buffer, a writeback to an empty slot, and address-matched loads.

// File: rtl/rob_pkg.sv
package rob_pkg;

    typedef enum logic [1:0] {
        KIND_BRANCH = 2'd0,
        KIND_STORE  = 2'd1,
        KIND_REGOP  = 2'd2
    } rob_kind_e;

    typedef struct packed {
        logic      valid;
        logic      done;
        logic      fault;
        logic      mispred;
        rob_kind_e kind;
    } rob_flags_t;

    typedef enum logic {
        CAUSE_MISPREDICT = 1'b0,
        CAUSE_EXCEPTION  = 1'b1
    } rob_cause_e;

endpackage

// File: rtl/rob_ring.sv
module rob_ring #(
    parameter int DEPTH = 8,
    parameter int TAG_W = 3,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             flush,
    output logic [TAG_W-1:0] head_o,
    output logic [TAG_W-1:0] tail_o,
    output logic [CNT_W-1:0] count_o,
    output logic             full_o
);

    typedef struct packed {
        logic [TAG_W-1:0] head;
        logic [TAG_W-1:0] tail;
        logic [CNT_W-1:0] count;
    } ring_t;

    ring_t ring_d, ring_q;

    function automatic logic [TAG_W-1:0] bump(input logic [TAG_W-1:0] p);
        if (p == TAG_W'(DEPTH - 1)) return '0;
        return p + 1'b1;
    endfunction

    always_comb begin
        ring_d = ring_q;
        if (flush) begin
            // Discard everything: tail falls back onto the head slot.
            ring_d.tail  = ring_q.head;
            ring_d.count = '0;
        end else begin
            if (push) ring_d.tail = bump(ring_q.tail);
            if (pop)  ring_d.head = bump(ring_q.head);
            ring_d.count = ring_q.count + CNT_W'(push) - CNT_W'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ring_q <= '0;
        else        ring_q <= ring_d;
    end

    assign head_o  = ring_q.head;
    assign tail_o  = ring_q.tail;
    assign count_o = ring_q.count;
    assign full_o  = (ring_q.count == CNT_W'(DEPTH));

    // R2: no slot is taken while every slot is occupied
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (ring_q.count < CNT_W'(DEPTH)));

    // R3: retirement never happens from an empty buffer
    p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (ring_q.count != '0));

endmodule

// File: rtl/rob_entries.sv
module rob_entries
    import rob_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int TAG_W  = 3,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          alloc_en,
    input  logic [TAG_W-1:0]              alloc_idx,
    input  rob_kind_e                     alloc_kind,
    input  logic [ADDR_W-1:0]             alloc_dest,
    input  logic                          wb_valid,
    input  logic [TAG_W-1:0]              wb_tag,
    input  logic [DATA_W-1:0]             wb_value,
    input  logic                          wb_exc,
    input  logic                          wb_mis,
    input  logic                          pop_en,
    input  logic [TAG_W-1:0]              pop_idx,
    input  logic                          flush,
    output rob_flags_t [DEPTH-1:0]        flags_o,
    output logic [DEPTH-1:0][ADDR_W-1:0]  dest_o,
    output logic [DEPTH-1:0][DATA_W-1:0]  value_o
);

    typedef struct packed {
        rob_flags_t [DEPTH-1:0]       fl;
        logic [DEPTH-1:0][ADDR_W-1:0] dest;
        logic [DEPTH-1:0][DATA_W-1:0] val;
    } slots_t;

    slots_t slots_d, slots_q;
    logic   wb_hit;

    // A result lands only on an occupied slot and never during a flush.
    assign wb_hit = wb_valid && !flush && (int'(wb_tag) < DEPTH)
                    && slots_q.fl[wb_tag].valid;

    always_comb begin
        slots_d = slots_q;
        if (flush) begin
            for (int i = 0; i < DEPTH; i++) begin
                slots_d.fl[i].valid = 1'b0;
                slots_d.fl[i].done  = 1'b0;
            end
        end else begin
            if (pop_en) begin
                slots_d.fl[pop_idx].valid = 1'b0;
                slots_d.fl[pop_idx].done  = 1'b0;
            end
            if (alloc_en) begin
                slots_d.fl[alloc_idx].valid   = 1'b1;
                slots_d.fl[alloc_idx].done    = 1'b0;
                slots_d.fl[alloc_idx].fault   = 1'b0;
                slots_d.fl[alloc_idx].mispred = 1'b0;
                slots_d.fl[alloc_idx].kind    = alloc_kind;
                slots_d.dest[alloc_idx]       = alloc_dest;
                slots_d.val[alloc_idx]        = '0;
            end
            if (wb_hit) begin
                slots_d.fl[wb_tag].done    = 1'b1;
                slots_d.fl[wb_tag].fault   = wb_exc;
                slots_d.fl[wb_tag].mispred = wb_mis;
                slots_d.val[wb_tag]        = wb_value;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) slots_q <= '0;
        else        slots_q <= slots_d;
    end

    assign flags_o = slots_q.fl;
    assign dest_o  = slots_q.dest;
    assign value_o = slots_q.val;

    // R7: a result aimed at an empty slot leaves it without a result
    p_wb_dead_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !flush && !slots_q.fl[wb_tag].valid)
        |=> !slots_q.fl[$past(wb_tag)].done);

    // R3: the slot being retired is occupied and complete
    p_pop_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pop_en |-> (slots_q.fl[pop_idx].valid && slots_q.fl[pop_idx].done));

    // R2: the tail slot handed out is free
    p_alloc_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> !slots_q.fl[alloc_idx].valid);

endmodule

// File: rtl/rob_ldguard.sv
module rob_ldguard
    import rob_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int TAG_W  = 3,
    parameter int ADDR_W = 16
) (
    input  rob_flags_t [DEPTH-1:0]       flags_i,
    input  logic [DEPTH-1:0][ADDR_W-1:0] dest_i,
    input  logic [TAG_W-1:0]             head_i,
    input  logic [TAG_W-1:0]             ld_tag,
    input  logic [ADDR_W-1:0]            ld_addr,
    output logic                         ld_block
);

    // Distance from the oldest slot; smaller means older.
    function automatic logic [TAG_W-1:0] age_of(input logic [TAG_W-1:0] idx,
                                                input logic [TAG_W-1:0] hd);
        if (idx >= hd) return idx - hd;
        return idx + TAG_W'(DEPTH) - hd;
    endfunction

    logic [TAG_W-1:0] ld_age;
    logic [DEPTH-1:0] match;

    assign ld_age = age_of(ld_tag, head_i);

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        logic [TAG_W-1:0] slot_age;
        assign slot_age = age_of(TAG_W'(g), head_i);
        assign match[g] = flags_i[g].valid
                          && (flags_i[g].kind == KIND_STORE)
                          && (dest_i[g] == ld_addr)
                          && (slot_age < ld_age);
    end

    assign ld_block = |match;

endmodule

// File: rtl/rob_core.sv
module rob_core
    import rob_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    localparam int TAG_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [1:0]        alloc_kind,
    input  logic [ADDR_W-1:0] alloc_dest,
    output logic              alloc_ready,
    output logic [TAG_W-1:0]  alloc_tag,
    input  logic              wb_valid,
    input  logic [TAG_W-1:0]  wb_tag,
    input  logic [DATA_W-1:0] wb_value,
    input  logic              wb_exc,
    input  logic              wb_mispredict,
    input  logic [TAG_W-1:0]  lookup_tag,
    output logic              lookup_ready,
    output logic [DATA_W-1:0] lookup_value,
    input  logic [TAG_W-1:0]  ld_tag,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic              ld_block,
    output logic              cm_reg_we,
    output logic              cm_mem_we,
    output logic [TAG_W-1:0]  cm_tag,
    output logic [ADDR_W-1:0] cm_dest,
    output logic [DATA_W-1:0] cm_value,
    output logic              flush,
    output logic              flush_cause,
    output logic [TAG_W-1:0]  flush_tag
);

    logic [TAG_W-1:0]             head, tail;
    logic [CNT_W-1:0]             count;
    logic                         full;
    rob_flags_t [DEPTH-1:0]       flags;
    logic [DEPTH-1:0][ADDR_W-1:0] dests;
    logic [DEPTH-1:0][DATA_W-1:0] values;

    rob_flags_t head_fl;
    logic       head_live, flush_now, pop, push;

    assign head_fl   = flags[head];
    assign head_live = head_fl.valid && head_fl.done;
    assign flush_now = head_live &&
                       (head_fl.fault ||
                        ((head_fl.kind == KIND_BRANCH) && head_fl.mispred));
    assign pop       = head_live && !flush_now;

    assign alloc_ready = !full && !flush_now;
    assign push        = alloc_valid && alloc_ready;
    assign alloc_tag   = tail;

    rob_ring #(.DEPTH(DEPTH), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (push),
        .pop     (pop),
        .flush   (flush_now),
        .head_o  (head),
        .tail_o  (tail),
        .count_o (count),
        .full_o  (full)
    );

    rob_entries #(.DEPTH(DEPTH), .TAG_W(TAG_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_slots (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_en   (push),
        .alloc_idx  (tail),
        .alloc_kind (rob_kind_e'(alloc_kind)),
        .alloc_dest (alloc_dest),
        .wb_valid   (wb_valid),
        .wb_tag     (wb_tag),
        .wb_value   (wb_value),
        .wb_exc     (wb_exc),
        .wb_mis     (wb_mispredict),
        .pop_en     (pop),
        .pop_idx    (head),
        .flush      (flush_now),
        .flags_o    (flags),
        .dest_o     (dests),
        .value_o    (values)
    );

    rob_ldguard #(.DEPTH(DEPTH), .TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_guard (
        .flags_i  (flags),
        .dest_i   (dests),
        .head_i   (head),
        .ld_tag   (ld_tag),
        .ld_addr  (ld_addr),
        .ld_block (ld_block)
    );

    assign lookup_ready = flags[lookup_tag].valid && flags[lookup_tag].done;
    assign lookup_value = values[lookup_tag];

    assign cm_reg_we   = pop && (head_fl.kind == KIND_REGOP);
    assign cm_mem_we   = pop && (head_fl.kind == KIND_STORE);
    assign cm_tag      = head;
    assign cm_dest     = dests[head];
    assign cm_value    = values[head];

    assign flush       = flush_now;
    assign flush_cause = head_fl.fault ? CAUSE_EXCEPTION : CAUSE_MISPREDICT;
    assign flush_tag   = head;

    // R5: after a flush the next tag handed out is the flushing slot
    p_flush_rewind_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (alloc_tag == $past(flush_tag)) && (count == '0));

    // R10: a retired slot does not retire again in the following cycle
    p_retire_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_reg_we || cm_mem_we)
        |=> !((cm_reg_we || cm_mem_we) && (cm_tag == $past(cm_tag))));

    // R6: an exception flush writes no architectural state
    p_fault_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && flush_cause) |-> !(cm_reg_we || cm_mem_we));

endmodule

// File: tb/rob_core_tb.sv
module rob_core_tb;

    localparam int D = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_valid = 1'b0;
    logic [1:0]  alloc_kind = '0;
    logic [15:0] alloc_dest = '0;
    logic        alloc_ready;
    logic [2:0]  alloc_tag;
    logic        wb_valid = 1'b0;
    logic [2:0]  wb_tag = '0;
    logic [31:0] wb_value = '0;
    logic        wb_exc = 1'b0;
    logic        wb_mispredict = 1'b0;
    logic [2:0]  lookup_tag = '0;
    logic        lookup_ready;
    logic [31:0] lookup_value;
    logic [2:0]  ld_tag = '0;
    logic [15:0] ld_addr = '0;
    logic        ld_block;
    logic        cm_reg_we, cm_mem_we;
    logic [2:0]  cm_tag;
    logic [15:0] cm_dest;
    logic [31:0] cm_value;
    logic        flush, flush_cause;
    logic [2:0]  flush_tag;

    int n_vec = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    rob_core #(.DEPTH(D), .ADDR_W(16), .DATA_W(32)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_kind(alloc_kind), .alloc_dest(alloc_dest),
        .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_value(wb_value),
        .wb_exc(wb_exc), .wb_mispredict(wb_mispredict),
        .lookup_tag(lookup_tag), .lookup_ready(lookup_ready), .lookup_value(lookup_value),
        .ld_tag(ld_tag), .ld_addr(ld_addr), .ld_block(ld_block),
        .cm_reg_we(cm_reg_we), .cm_mem_we(cm_mem_we), .cm_tag(cm_tag),
        .cm_dest(cm_dest), .cm_value(cm_value),
        .flush(flush), .flush_cause(flush_cause), .flush_tag(flush_tag)
    );

    // reference model state (mirrors the slots after the last clock edge)
    bit          mv[D];
    int          mk[D];
    logic [15:0] md[D];
    logic [31:0] mval[D];
    bit          mdone[D];
    bit          mexc[D];
    bit          mmis[D];
    int          mhead, mcnt;

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic clear_inputs();
        alloc_valid = 1'b0; wb_valid = 1'b0; wb_exc = 1'b0; wb_mispredict = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        clear_inputs();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_alloc(input int kind, input logic [15:0] dest);
        alloc_valid = 1'b1; alloc_kind = 2'(kind); alloc_dest = dest;
        @(negedge clk);
        alloc_valid = 1'b0;
    endtask

    task automatic do_wb(input int tag, input logic [31:0] val, input bit exc, input bit mis);
        wb_valid = 1'b1; wb_tag = 3'(tag); wb_value = val; wb_exc = exc; wb_mispredict = mis;
        @(negedge clk);
        wb_valid = 1'b0; wb_exc = 1'b0; wb_mispredict = 1'b0;
    endtask

    function automatic bit exp_block(input int tag, input logic [15:0] a);
        int la = (tag - mhead + D) % D;
        bit r = 1'b0;
        for (int i = 0; i < D; i++)
            if (mv[i] && mk[i] == 1 && md[i] == a && ((i - mhead + D) % D) < la) r = 1'b1;
        return r;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got hang expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED_0421);

        // ---------------- R1 reset state
        do_reset();
        lookup_tag = 3'd0; #1;
        check("R1 alloc_ready", alloc_ready, 1);
        check("R1 alloc_tag", alloc_tag, 0);
        check("R1 cm_reg_we", cm_reg_we, 0);
        check("R1 cm_mem_we", cm_mem_we, 0);
        check("R1 flush", flush, 0);
        check("R1 lookup_ready", lookup_ready, 0);

        // ---------------- R2 fill, R9 ignored alloc when full
        for (int i = 0; i < D; i++) begin
            check("R2 alloc_tag", alloc_tag, i);
            do_alloc(2, 16'(i + 1));
        end
        check("R2 full alloc_ready", alloc_ready, 0);
        do_alloc(1, 16'h0099);

        // ---------------- R4 lookup, R10 ordering, R3 retire
        do_wb(3, 32'h33, 0, 0);
        lookup_tag = 3'd3; #1;
        check("R4 lookup_ready", lookup_ready, 1);
        check("R4 lookup_value", lookup_value, 32'h33);
        lookup_tag = 3'd0; #1;
        check("R4 pending lookup_ready", lookup_ready, 0);
        check("R10 younger waits", cm_reg_we, 0);
        do_wb(0, 32'hA0, 0, 0);
        check("R3 cm_reg_we", cm_reg_we, 1);
        check("R3 cm_dest", cm_dest, 1);
        check("R3 cm_value", cm_value, 32'hA0);
        check("R3 cm_tag", cm_tag, 0);
        @(negedge clk);
        check("R9 alloc_ready after pop", alloc_ready, 1);
        check("R9 tail unmoved", alloc_tag, 0);
        check("R10 head 1 not done", cm_reg_we, 0);

        // ---------------- R7 writeback to empty slot
        do_reset();
        do_wb(5, 32'h55, 0, 0);
        lookup_tag = 3'd5; #1;
        check("R7 empty slot", lookup_ready, 0);
        for (int i = 0; i < 6; i++) do_alloc(2, 16'(i));
        lookup_tag = 3'd5; #1;
        check("R7 no stale result", lookup_ready, 0);
        check("R7 no retire", cm_reg_we, 0);

        // ---------------- R8 load guard
        do_reset();
        do_alloc(1, 16'h40);
        do_alloc(2, 16'h2);
        do_alloc(1, 16'h44);
        ld_tag = 3'd1; ld_addr = 16'h40; #1;
        check("R8 older store match", ld_block, 1);
        ld_addr = 16'h44; #1;
        check("R8 younger store", ld_block, 0);
        ld_tag = 3'd2; #1;
        check("R8 own slot", ld_block, 0);
        ld_tag = 3'd1; ld_addr = 16'h50; #1;
        check("R8 other address", ld_block, 0);
        do_wb(0, 32'hBEEF, 0, 0);
        check("R3 store cm_mem_we", cm_mem_we, 1);
        check("R3 store cm_dest", cm_dest, 16'h40);
        check("R3 store no reg write", cm_reg_we, 0);
        @(negedge clk);
        ld_tag = 3'd1; ld_addr = 16'h40; #1;
        check("R8 store retired", ld_block, 0);

        // ---------------- R5 mispredict
        do_reset();
        do_alloc(0, 16'h0);
        do_alloc(2, 16'h5);
        do_alloc(2, 16'h6);
        do_wb(1, 32'h11, 0, 0);
        do_wb(2, 32'h22, 0, 0);
        do_wb(0, 32'h0, 0, 1);
        check("R5 flush", flush, 1);
        check("R5 cause", flush_cause, 0);
        check("R5 flush_tag", flush_tag, 0);
        check("R5 no write", cm_reg_we, 0);
        check("R9 alloc blocked in flush", alloc_ready, 0);
        @(negedge clk);
        lookup_tag = 3'd1; #1;
        check("R5 flush done", flush, 0);
        check("R5 tail rewound", alloc_tag, 0);
        check("R5 slots dropped", lookup_ready, 0);
        check("R5 no retire after", cm_reg_we, 0);

        // ---------------- R6 exception
        do_reset();
        do_alloc(2, 16'h1);
        do_alloc(2, 16'h2);
        do_alloc(2, 16'h3);
        do_wb(1, 32'h11, 1, 0);
        do_wb(2, 32'h22, 0, 0);
        check("R6 deferred", flush, 0);
        check("R10 blocked by head", cm_reg_we, 0);
        do_wb(0, 32'h10, 0, 0);
        check("R3 older retires first", cm_reg_we, 1);
        check("R3 tag0", cm_tag, 0);
        @(negedge clk);
        check("R6 flush", flush, 1);
        check("R6 cause", flush_cause, 1);
        check("R6 flush_tag", flush_tag, 1);
        check("R6 no write", cm_reg_we, 0);
        @(negedge clk);
        lookup_tag = 3'd2; #1;
        check("R6 tail at fault", alloc_tag, 1);
        check("R6 younger dropped", lookup_ready, 0);

        // ---------------- random phase
        do_reset();
        for (int i = 0; i < D; i++) begin
            mv[i] = 0; mdone[i] = 0; mexc[i] = 0; mmis[i] = 0; mk[i] = 0; md[i] = '0; mval[i] = '0;
        end
        mhead = 0; mcnt = 0;
        begin
            bit p_alloc = 0, p_wb = 0, p_pop = 0, p_flush = 0;
            int p_ak = 0, p_wt = 0;
            logic [15:0] p_ad = '0;
            logic [31:0] p_wv = '0;
            bit p_we = 0, p_wm = 0;
            for (int cyc = 0; cyc < 4000; cyc++) begin
                bit hv, efl, epop;
                int t;
                // fold last cycle's stimulus into the model
                if (p_flush) begin
                    for (int i = 0; i < D; i++) begin mv[i] = 0; mdone[i] = 0; end
                    mcnt = 0;
                end else if (p_pop) begin
                    mv[mhead] = 0; mdone[mhead] = 0;
                    mhead = (mhead + 1) % D; mcnt--;
                end
                if (p_alloc) begin
                    t = (mhead + mcnt) % D;
                    mv[t] = 1; mk[t] = p_ak; md[t] = p_ad; mdone[t] = 0;
                    mexc[t] = 0; mmis[t] = 0; mval[t] = '0; mcnt++;
                end
                if (p_wb) begin
                    mdone[p_wt] = 1; mval[p_wt] = p_wv; mexc[p_wt] = p_we; mmis[p_wt] = p_wm;
                end
                p_alloc = 0; p_wb = 0;
                clear_inputs();

                // expected outputs
                hv   = (mcnt > 0) && mdone[mhead];
                efl  = hv && (mexc[mhead] || (mk[mhead] == 0 && mmis[mhead]));
                epop = hv && !efl;
                lookup_tag = 3'($urandom % D);
                ld_tag     = 3'($urandom % D);
                ld_addr    = 16'($urandom % 4);
                #1;
                check("R3 cm_reg_we", cm_reg_we, epop && mk[mhead] == 2);
                check("R3 cm_mem_we", cm_mem_we, epop && mk[mhead] == 1);
                if (epop && mk[mhead] != 0) begin
                    check("R10 cm_tag", cm_tag, mhead);
                    check("R3 cm_dest", cm_dest, md[mhead]);
                    check("R3 cm_value", cm_value, mval[mhead]);
                end
                check("R5 R6 flush", flush, efl);
                if (efl) begin
                    check("R6 flush_cause", flush_cause, mexc[mhead]);
                    check("R5 flush_tag", flush_tag, mhead);
                end
                check("R2 alloc_ready", alloc_ready, (mcnt < D) && !efl);
                if (mcnt < D && !efl) check("R2 alloc_tag", alloc_tag, (mhead + mcnt) % D);
                check("R4 lookup_ready", lookup_ready, mv[lookup_tag] && mdone[lookup_tag]);
                if (mv[lookup_tag] && mdone[lookup_tag])
                    check("R4 lookup_value", lookup_value, mval[lookup_tag]);
                check("R8 ld_block", ld_block, exp_block(int'(ld_tag), ld_addr));
                p_pop = epop; p_flush = efl;

                // new stimulus
                if (!efl && mcnt < D && ($urandom % 4) != 0) begin
                    p_alloc = 1; p_ak = $urandom % 3; p_ad = 16'($urandom % 4);
                    alloc_valid = 1; alloc_kind = 2'(p_ak); alloc_dest = p_ad;
                end else if (($urandom % 16) == 0) begin
                    // request that must be ignored (R9) when alloc_ready is low
                    if (efl || mcnt >= D) begin
                        alloc_valid = 1; alloc_kind = 2'd2; alloc_dest = 16'h3;
                    end
                end
                if (!efl && ($urandom % 3) != 0) begin
                    int r = $urandom % D;
                    if (mv[r] && !mdone[r] && !(epop && r == mhead)) begin
                        p_wb = 1; p_wt = r; p_wv = $urandom;
                        p_we = (mk[r] != 0) && (($urandom % 16) == 0);
                        p_wm = (mk[r] == 0) && (($urandom % 4) == 0);
                        wb_valid = 1; wb_tag = 3'(r); wb_value = p_wv;
                        wb_exc = p_we; wb_mispredict = p_wm;
                    end else if (!mv[r] && ($urandom % 4) == 0) begin
                        // R7: result for an empty slot, model unchanged
                        wb_valid = 1; wb_tag = 3'(r); wb_value = $urandom;
                        wb_exc = 0; wb_mispredict = 0;
                    end
                end
                @(negedge clk);
            end
        end
        clear_inputs();

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule